// File: doc/BRIEF.md
# Upper-Level Cache Presence Filter

This block lives inside one crosspoint cache and keeps a record of which of that cache's lines are also held by the small direct-mapped cache on the processor chip. Each processor-side line can be loaded only through a crosspoint cache, so every load is seen here. For each processor-side slot that this crosspoint cache can feed, the block stores the extra crosspoint index bits of the line last loaded into that slot, plus a valid bit. Presence is therefore one slot read and one short compare, not a bit per crosspoint line.

A query arrives in two cases: a write to a shared line hits in the crosspoint cache, or the crosspoint cache evicts a line. When the query's extra index bits equal the stored field of a valid slot, the block raises an invalidation request toward the processor-bus arbiter. The request holds the line index and the cause until the arbiter acknowledges it. Issuing the request empties the slot. A query that misses the filter creates no processor-bus traffic.

Addresses are given as the crosspoint line index. Index bits [SLOT_W-1:0] (address bits [9:6] with the defaults) pick one of the slots. Bits [IDX_W-1:SLOT_W] (address bits [15:10]) form the stored field.

Top module: `uc_presence_filter`

## Requirements
- R1: After reset every slot is empty: no query raises `invReq`, and `invReq` is low with `queryReady` high.
- R2: A pulse on `fillValid` stores `fillIdx[IDX_W-1:SLOT_W]` into the slot numbered `fillIdx[SLOT_W-1:0]` and marks that slot valid. An accepted query with the same index then raises `invReq` one cycle after the query edge, with `invIdx` equal to the query index.
- R3: A query whose slot is valid but whose field bits differ from the stored field raises no request.
- R4: Slots are independent. A fill or a clear of one slot never changes the answer for any other slot.
- R5: `invIsEvict` reports the cause of the pending request: 1 when the accepted query had `qEvict`=1 (eviction), 0 when it had `qEvict`=0 (shared write hit). Both causes raise a request on a match.
- R6: While `invReq` is high and `invAck` is low, `invReq`, `invIdx` and `invIsEvict` stay unchanged. `invReq` is low in the cycle after an edge where it was high with `invAck` high.
- R7: `queryReady` is low exactly while a request is pending. A query offered then is ignored: it clears no slot and raises no request.
- R8: An accepted query that matches clears the valid bit of its slot. A second query for the same line, with no fill between the two, raises no request.
- R9: When a fill and a query address the same slot in the same cycle, the query is answered from the contents before the fill. The fill is always recorded, even when that query matched.
- R10: A later fill to a slot replaces its field, so a line that was replaced no longer matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | Processor-side cache loaded a line this cycle |
| fillIdx | input | IDX_W | Crosspoint line index of the loaded line |
| qValid | input | 1 | Presence query this cycle |
| qEvict | input | 1 | Query cause: 1 eviction, 0 shared write hit |
| qIdx | input | IDX_W | Crosspoint line index being queried |
| queryReady | output | 1 | A query is accepted this cycle |
| invReq | output | 1 | Invalidation request to the processor-bus arbiter |
| invIdx | output | IDX_W | Line index to invalidate, held while pending |
| invIsEvict | output | 1 | Cause of the pending request |
| invAck | input | 1 | Arbiter grant; ends the pending request |

## Verification
The bench uses the default SLOT_W=4 and EXT_W=6, giving 16 slots with a 6-bit field each. At this size every slot paired with every one of its 64 field values can be queried: 1024 queries that the bench compares against an arithmetic model of the stored fields. On top of the sweep, directed sequences cover a request held without acknowledge, queries offered while busy, fills that overwrite a slot, and a fill and a query to one slot in the same cycle.

// File: rtl/uc_presence_pkg.sv
package uc_presence_pkg;

  // Strobes sent from the control path to the slot store.
  typedef struct packed {
    logic recordFill;  // write the fill field into its slot and set valid
    logic clearSlot;   // drop valid of the queried slot
    logic loadInv;     // capture the queried index and cause into the request register
  } ctlStrobe_t;

endpackage

// File: rtl/uc_presence_dp.sv
module uc_presence_dp
  import uc_presence_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int EXT_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctlStrobe_t              strobe,
  input  logic [SLOT_W+EXT_W-1:0] fillIdx,
  input  logic [SLOT_W+EXT_W-1:0] qIdx,
  input  logic                    qEvict,
  output logic                    match,
  output logic [SLOT_W+EXT_W-1:0] invIdx,
  output logic                    invIsEvict
);
  localparam int IDX_W = SLOT_W + EXT_W;
  localparam int NSLOT = 1 << SLOT_W;

  logic [SLOT_W-1:0] fillSlot, qSlot;
  logic [EXT_W-1:0]  fillExt, qExt;
  logic [EXT_W-1:0]  extArr   [NSLOT];
  logic              validArr [NSLOT];

  assign fillSlot = fillIdx[SLOT_W-1:0];
  assign fillExt  = fillIdx[IDX_W-1:SLOT_W];
  assign qSlot    = qIdx[SLOT_W-1:0];
  assign qExt     = qIdx[IDX_W-1:SLOT_W];

  // One field register per slot. A fill has priority over a clear of the same slot.
  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        validArr[s] <= 1'b0;
        extArr[s]   <= '0;
      end else if (strobe.recordFill && fillSlot == SLOT_W'(s)) begin
        validArr[s] <= 1'b1;
        extArr[s]   <= fillExt;
      end else if (strobe.clearSlot && qSlot == SLOT_W'(s)) begin
        validArr[s] <= 1'b0;
      end
    end
  end

  // The compare reads the registered contents, so a fill in the same cycle is not seen.
  always_comb begin
    match = validArr[qSlot] && (extArr[qSlot] == qExt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invIdx     <= '0;
      invIsEvict <= 1'b0;
    end else if (strobe.loadInv) begin
      invIdx     <= qIdx;
      invIsEvict <= qEvict;
    end
  end
endmodule

// File: rtl/uc_presence_ctl.sv
module uc_presence_ctl
  import uc_presence_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fillValid,
  input  logic       qValid,
  input  logic       match,
  input  logic       invAck,
  output ctlStrobe_t strobe,
  output logic       invReq,
  output logic       queryReady
);
  logic accept;

  assign queryReady = !invReq;
  assign accept     = qValid && queryReady;

  always_comb begin
    strobe            = '0;
    strobe.recordFill = fillValid;
    strobe.clearSlot  = accept && match;
    strobe.loadInv    = accept && match;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      invReq <= 1'b0;
    end else if (strobe.loadInv) begin
      invReq <= 1'b1;
    end else if (invAck) begin
      invReq <= 1'b0;
    end
  end
endmodule

// File: rtl/uc_presence_filter.sv
module uc_presence_filter
  import uc_presence_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int EXT_W  = 6,
  localparam int IDX_W = SLOT_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fillValid,
  input  logic [IDX_W-1:0] fillIdx,
  input  logic             qValid,
  input  logic             qEvict,
  input  logic [IDX_W-1:0] qIdx,
  output logic             queryReady,
  output logic             invReq,
  output logic [IDX_W-1:0] invIdx,
  output logic             invIsEvict,
  input  logic             invAck
);
  ctlStrobe_t strobe;
  logic       match;

  uc_presence_ctl uCtl (
    .clk        (clk),
    .rst_n      (rst_n),
    .fillValid  (fillValid),
    .qValid     (qValid),
    .match      (match),
    .invAck     (invAck),
    .strobe     (strobe),
    .invReq     (invReq),
    .queryReady (queryReady)
  );

  uc_presence_dp #(.SLOT_W(SLOT_W), .EXT_W(EXT_W)) uDp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .fillIdx    (fillIdx),
    .qIdx       (qIdx),
    .qEvict     (qEvict),
    .match      (match),
    .invIdx     (invIdx),
    .invIsEvict (invIsEvict)
  );
endmodule

// File: rtl/uc_presence_chk.sv
module uc_presence_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             qValid,
  input logic             queryReady,
  input logic             invReq,
  input logic [IDX_W-1:0] invIdx,
  input logic             invIsEvict,
  input logic             invAck
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !invReq); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    invReq && !invAck |=> invReq && $stable(invIdx) && $stable(invIsEvict)); // R6

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    invReq && invAck |=> !invReq); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    invReq |-> !queryReady); // R7

  AST_REQ_FROM_QUERY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(invReq) |-> $past(qValid && queryReady)); // R2
endmodule

bind uc_presence_filter uc_presence_chk #(.IDX_W(IDX_W)) uChk (
  .clk        (clk),
  .rst_n      (rst_n),
  .qValid     (qValid),
  .queryReady (queryReady),
  .invReq     (invReq),
  .invIdx     (invIdx),
  .invIsEvict (invIsEvict),
  .invAck     (invAck)
);

// File: tb/tb_uc_presence_filter.sv
module tb_uc_presence_filter;
  localparam int SLOT_W = 4;
  localparam int EXT_W  = 6;
  localparam int IDX_W  = SLOT_W + EXT_W;
  localparam int NSLOT  = 1 << SLOT_W;
  localparam int NEXT   = 1 << EXT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             fillValid = 1'b0;
  logic [IDX_W-1:0] fillIdx = '0;
  logic             qValid = 1'b0;
  logic             qEvict = 1'b0;
  logic [IDX_W-1:0] qIdx = '0;
  logic             queryReady;
  logic             invReq;
  logic [IDX_W-1:0] invIdx;
  logic             invIsEvict;
  logic             invAck = 1'b0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int mExt [NSLOT];
  bit mVal [NSLOT];

  always #5 clk = ~clk;

  uc_presence_filter #(.SLOT_W(SLOT_W), .EXT_W(EXT_W)) dut (
    .clk(clk), .rst_n(rst_n), .fillValid(fillValid), .fillIdx(fillIdx),
    .qValid(qValid), .qEvict(qEvict), .qIdx(qIdx), .queryReady(queryReady),
    .invReq(invReq), .invIdx(invIdx), .invIsEvict(invIsEvict), .invAck(invAck)
  );

  function automatic logic [IDX_W-1:0] mkIdx(int slot, int ext);
    return IDX_W'(ext * NSLOT + slot);
  endfunction

  task automatic check(bit ok, string req, int actual, int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic doFill(int slot, int ext);
    fillValid = 1'b1;
    fillIdx   = mkIdx(slot, ext);
    @(negedge clk);
    fillValid = 1'b0;
    mVal[slot] = 1'b1;
    mExt[slot] = ext;
  endtask

  task automatic ackPending(string req);
    invAck = 1'b1;
    @(negedge clk);
    invAck = 1'b0;
    check(invReq == 1'b0, req, int'(invReq), 0);
  endtask

  task automatic doQuery(int slot, int ext, bit ev, string req);
    bit exp;
    exp = mVal[slot] && (mExt[slot] == ext);
    qValid = 1'b1;
    qEvict = ev;
    qIdx   = mkIdx(slot, ext);
    @(negedge clk);
    qValid = 1'b0;
    check(invReq == exp, req, int'(invReq), int'(exp));
    if (exp && invReq) begin
      check(invIdx == mkIdx(slot, ext), req, int'(invIdx), int'(mkIdx(slot, ext)));
      check(invIsEvict == ev, "R5", int'(invIsEvict), int'(ev));
      mVal[slot] = 1'b0;
      ackPending("R6");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NSLOT; s++) begin
      mVal[s] = 1'b0;
      mExt[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset, and every slot is empty
    check(invReq == 1'b0, "R1", int'(invReq), 0);
    check(queryReady == 1'b1, "R1", int'(queryReady), 1);
    for (int s = 0; s < NSLOT; s++) doQuery(s, (s * 5) % NEXT, 1'b0, "R1");

    // R2/R3/R4/R8: fill every slot, then sweep every (slot, field) pair
    for (int s = 0; s < NSLOT; s++) doFill(s, (s * 7 + 3) % NEXT);
    for (int s = 0; s < NSLOT; s++) begin
      for (int e = 0; e < NEXT; e++) begin
        doQuery(s, e, 1'(e % 2), (e == (s * 7 + 3) % NEXT) ? "R2" : "R3_R4");
      end
    end
    // R8: the sweep hit each stored line once, so a repeat query finds nothing
    for (int s = 0; s < NSLOT; s++) doQuery(s, (s * 7 + 3) % NEXT, 1'b0, "R8");

    // R10: an overwriting fill replaces the field
    doFill(2, 10);
    doFill(2, 20);
    doQuery(2, 10, 1'b0, "R10");
    doQuery(2, 20, 1'b1, "R10");

    // R5: write-hit cause
    doFill(3, 33);
    doQuery(3, 33, 1'b0, "R5");

    // R6 and R7: hold without acknowledge, queries offered while busy are ignored
    doFill(4, 40);
    doFill(6, 60);
    qValid = 1'b1; qEvict = 1'b1; qIdx = mkIdx(4, 40);
    @(negedge clk);
    qValid = 1'b0;
    check(invReq == 1'b1, "R2", int'(invReq), 1);
    mVal[4] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      qValid = 1'b1; qEvict = 1'b0; qIdx = mkIdx(6, 60);
      check(queryReady == 1'b0, "R7", int'(queryReady), 0);
      @(negedge clk);
      qValid = 1'b0;
      check(invReq == 1'b1, "R6", int'(invReq), 1);
      check(invIdx == mkIdx(4, 40), "R6", int'(invIdx), int'(mkIdx(4, 40)));
      check(invIsEvict == 1'b1, "R6", int'(invIsEvict), 1);
    end
    ackPending("R6");
    check(queryReady == 1'b1, "R7", int'(queryReady), 1);
    doQuery(6, 60, 1'b0, "R7");

    // R9: same-cycle fill and query to one slot, query uses the old field
    doFill(5, 11);
    fillValid = 1'b1; fillIdx = mkIdx(5, 22);
    qValid = 1'b1; qEvict = 1'b0; qIdx = mkIdx(5, 11);
    @(negedge clk);
    fillValid = 1'b0; qValid = 1'b0;
    check(invReq == 1'b1, "R9", int'(invReq), 1);
    check(invIdx == mkIdx(5, 11), "R9", int'(invIdx), int'(mkIdx(5, 11)));
    ackPending("R9");
    mVal[5] = 1'b1; mExt[5] = 22;
    doQuery(5, 22, 1'b0, "R9");

    doFill(7, 1);
    fillValid = 1'b1; fillIdx = mkIdx(7, 2);
    qValid = 1'b1; qEvict = 1'b0; qIdx = mkIdx(7, 2);
    @(negedge clk);
    fillValid = 1'b0; qValid = 1'b0;
    check(invReq == 1'b0, "R9", int'(invReq), 0);
    mVal[7] = 1'b1; mExt[7] = 2;
    doQuery(7, 2, 1'b1, "R9");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule